// File: doc/BRIEF.md
# Thermal Alert Output Controller

This block owns the control register of a temperature monitor and decides when the monitor's open-drain alert pin is pulled. It takes three trip flags that a separate comparator stage computes (at or above critical, above the alarm window, below the alarm window), a strobe marking each new temperature sample, and register-write requests decoded from a host bus. From these it drives the alert pin, returns the control register's read value, and grants or refuses writes to the three threshold registers.

Three alert behaviours can be selected. In comparator mode the alert follows the trip flags. In interrupt mode it latches on window crossings until software clears it. In critical-only mode it follows the critical flag alone. The critical flag always overrides a software clear. A clear issued during a critical condition is held back and takes effect when the critical flag drops. Two sticky lock bits freeze parts of the configuration and the threshold registers until reset.

Top module: `thermal_alert_ctrl`

## Requirements
- R1: After reset the control register reads 0x0000, the alert output is disabled (`alert_oe`=0, `alert_level`=1), and threshold writes are permitted.
- R2: The control register read value is {5'b0, hyst[1:0], shutdown, crit_lock, win_lock, clear=0, status, enable, crit_only, polarity, mode}, with mode at bit 0 and hyst at bits 10:9. Bits 15:11 and bit 5 always read 0, and writes to bit 4 are ignored.
- R3: Comparator mode (bit 0 = 0): the alert is asserted exactly while any trip flag is set. Writing 1 to the clear bit (bit 5) has no effect in this mode.
- R4: Interrupt mode (bit 0 = 1): on a sample strobe where the {above, below} flag pair differs from the pair at the previous strobe, the alert latches. It stays asserted until a clear write, and a steady out-of-window pair does not re-trigger it.
- R5: In interrupt mode the alert is asserted while the critical flag is set, and a clear cannot deassert it. A clear attempted during that time takes effect as soon as the critical flag drops. Without such a clear, a latched alert stays asserted after the critical flag drops.
- R6: With crit_only (bit 2) set, the alert is asserted only while the critical flag is set, in either mode.
- R7: When enabled (bit 3 = 1) and not in shutdown, the pin is pulled low (`alert_oe`=1, `alert_level`=0) when asserted with polarity 0, or when deasserted with polarity 1. When disabled the pin is released. The status bit (bit 4) reports the assertion regardless of polarity.
- R8: The lock bits (bit 6 window lock, bit 7 critical lock) are sticky until reset. While either lock is set, bits 0, 1, 3 and 10:9 keep their value, and bit 2 keeps its value while the window lock is set. A lock takes effect from the write after the one that sets it.
- R9: A write request to the upper or lower window threshold is permitted only while the window lock is clear. A write request to the critical threshold is permitted only while the critical lock is clear.
- R10: Shutdown (bit 8) cannot be set while either lock is set, but it can always be cleared. In shutdown no alert is asserted and the pin is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trip_crit | input | 1 | Temperature at or above critical threshold |
| trip_above | input | 1 | Temperature above alarm window |
| trip_below | input | 1 | Temperature below alarm window |
| sample_stb | input | 1 | New temperature sample available |
| wr_en | input | 1 | Register write request |
| wr_sel | input | 2 | Target register: 0 control, 1 window upper, 2 window lower, 3 critical |
| wr_data | input | 16 | Write data |
| cfg_rdata | output | 16 | Control register read value |
| alert_level | output | 1 | Resulting pin level (0 when pulled low) |
| alert_oe | output | 1 | Pin pull-down enable |
| win_hi_wr_ok | output | 1 | Upper window threshold write permitted |
| win_lo_wr_ok | output | 1 | Lower window threshold write permitted |
| crit_wr_ok | output | 1 | Critical threshold write permitted |

## Verification
The bench focuses on the critical/clear interplay. A clear issued during a critical condition must release the alert the moment the flag drops, and without such a clear the alert must persist. A design that drops the pending clear would keep the pin asserted, and one that lets clear act during critical would release it too early. The bench also checks that a repeated sample with an unchanged out-of-window pair does not re-arm an interrupt, since an edge detector keyed on levels would raise it again. Lock tests write frozen fields, set shutdown, and clear shutdown under a lock to catch a lock applied to the wrong bits or one that blocks the always-permitted shutdown exit.

// File: rtl/thal_pkg.sv
// Shared types for the thermal alert controller.
// Field positions in the control word are fixed by the host software view.
package thal_pkg;
    localparam int CFG_W  = 16;
    localparam int SEL_W  = 2;
    localparam int HYST_W = 2;

    localparam int B_MODE  = 0;
    localparam int B_POL   = 1;
    localparam int B_CONLY = 2;
    localparam int B_EN    = 3;
    localparam int B_STAT  = 4;
    localparam int B_CLR   = 5;
    localparam int B_WLOCK = 6;
    localparam int B_CLOCK = 7;
    localparam int B_SD    = 8;
    localparam int B_HYST  = 9;

    typedef enum logic [SEL_W-1:0] {
        SEL_CFG    = 2'd0,
        SEL_WIN_HI = 2'd1,
        SEL_WIN_LO = 2'd2,
        SEL_CRIT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [HYST_W-1:0] hyst;
        logic              sd;
        logic              crit_lock;
        logic              win_lock;
        logic              crit_only;
        logic              en;
        logic              pol;
        logic              mode;
    } cfg_t;
endpackage

// File: rtl/thal_cfg_regs.sv
// Control register storage with lock rules.
// Assumes one write per cycle; lock checks use the lock values held before the write.
module thal_cfg_regs
    import thal_pkg::*;
#(
    parameter int DW = CFG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [DW-1:0]    wr_data,
    output cfg_t             cfg,
    output logic             clr_req,
    output logic             win_hi_wr_ok,
    output logic             win_lo_wr_ok,
    output logic             crit_wr_ok
);
    logic cfg_wr;
    logic any_lock;
    logic unused_bits;

    assign cfg_wr      = wr_en && (wr_sel == SEL_CFG);
    assign any_lock    = cfg.win_lock | cfg.crit_lock;
    assign unused_bits = ^{wr_data[DW-1:B_HYST+HYST_W], wr_data[B_STAT]};

    // Write-once locks gate the threshold registers.
    assign win_hi_wr_ok = wr_en && (wr_sel == SEL_WIN_HI) && !cfg.win_lock;
    assign win_lo_wr_ok = wr_en && (wr_sel == SEL_WIN_LO) && !cfg.win_lock;
    assign crit_wr_ok   = wr_en && (wr_sel == SEL_CRIT)   && !cfg.crit_lock;

    // Clear is a pulse; it is never stored.
    assign clr_req = cfg_wr && wr_data[B_CLR];

    // Update control fields honouring the lock in force before this write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (cfg_wr) begin
            if (!any_lock) begin
                cfg.mode <= wr_data[B_MODE];
                cfg.pol  <= wr_data[B_POL];
                cfg.en   <= wr_data[B_EN];
                cfg.hyst <= wr_data[B_HYST +: HYST_W];
                cfg.sd   <= wr_data[B_SD];
            end else begin
                cfg.sd   <= cfg.sd & wr_data[B_SD];
            end
            if (!cfg.win_lock)
                cfg.crit_only <= wr_data[B_CONLY];
            cfg.win_lock  <= cfg.win_lock  | wr_data[B_WLOCK];
            cfg.crit_lock <= cfg.crit_lock | wr_data[B_CLOCK];
        end
    end

    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.win_lock && cfg.crit_lock) |=> (cfg.win_lock && cfg.crit_lock) || $past(cfg.win_lock && !cfg.crit_lock)
        || $past(!cfg.win_lock && cfg.crit_lock)) else $error("a_r8_lock_sticky");
    a_r8_win_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.win_lock |=> cfg.win_lock) else $error("a_r8_win_lock_hold");
    a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        any_lock |=> $stable({cfg.mode, cfg.pol, cfg.en, cfg.hyst})) else $error("a_r8_frozen");
    a_r9_permit: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.win_lock |-> (!win_hi_wr_ok && !win_lo_wr_ok)) else $error("a_r9_permit");
    a_r10_sd_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (any_lock && !cfg.sd) |=> !cfg.sd) else $error("a_r10_sd_no_set");
endmodule

// File: rtl/thal_irq_track.sv
// Interrupt-mode latch: detects window crossings at sample strobes and
// handles software clear, including a clear deferred by a critical condition.
// Assumes trip flags are stable between strobes.
module thal_irq_track (
    input  logic clk,
    input  logic rst_n,
    input  logic int_mode,
    input  logic active,
    input  logic sample_stb,
    input  logic trip_above,
    input  logic trip_below,
    input  logic trip_crit,
    input  logic clr_req,
    output logic irq_hold
);
    logic [1:0] prev_win;
    logic       flag_q;
    logic       pend_q;
    logic       crossing;

    assign crossing = sample_stb && active && ({trip_above, trip_below} != prev_win);
    // A pending clear masks the latch as soon as the critical flag is gone.
    assign irq_hold = flag_q & ~pend_q;

    // Remember the window flag pair seen at the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_win <= 2'b00;
        else if (sample_stb)
            prev_win <= {trip_above, trip_below};
    end

    // Latch crossings; apply or defer clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (!int_mode) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (crossing) begin
            flag_q <= 1'b1;
            pend_q <= 1'b0;
        end else if (clr_req && !trip_crit) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (clr_req) begin
            pend_q <= 1'b1;
        end else if (pend_q && !trip_crit) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end
    end

    a_r4_cross_latches: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && crossing) |=> irq_hold) else $error("a_r4_cross_latches");
    a_r5_clear_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mode && clr_req && trip_crit && !crossing) |=> !irq_hold) else $error("a_r5_clear_deferred");
endmodule

// File: rtl/thal_pin_drive.sv
// Open-drain pin driver: maps the internal assertion and polarity to a pull-down.
// Assumes an external pull-up, so a released pin reads 1.
module thal_pin_drive (
    input  logic asserted,
    input  logic out_on,
    input  logic pol_high,
    output logic pin_oe,
    output logic pin_level
);
    // Pull low for an active-low assertion or an idle active-high output.
    assign pin_oe    = out_on & (asserted ^ pol_high);
    assign pin_level = ~pin_oe;
endmodule

// File: rtl/thermal_alert_ctrl.sv
// Thermal alert controller top: selects the alert condition for the mode,
// gates it by enable and shutdown, and presents the control register read value.
// Assumes trip flags come from an external comparator with hysteresis applied.
module thermal_alert_ctrl
    import thal_pkg::*;
#(
    parameter int DW = CFG_W,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip_crit,
    input  logic          trip_above,
    input  logic          trip_below,
    input  logic          sample_stb,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] cfg_rdata,
    output logic          alert_level,
    output logic          alert_oe,
    output logic          win_hi_wr_ok,
    output logic          win_lo_wr_ok,
    output logic          crit_wr_ok
);
    localparam int RSV_W = DW - (B_HYST + HYST_W);

    cfg_t cfg;
    logic clr_req;
    logic irq_hold;
    logic out_on;
    logic cond;
    logic asserted;

    thal_cfg_regs #(.DW(DW)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_sel       (reg_sel_e'(wr_sel)),
        .wr_data      (wr_data),
        .cfg          (cfg),
        .clr_req      (clr_req),
        .win_hi_wr_ok (win_hi_wr_ok),
        .win_lo_wr_ok (win_lo_wr_ok),
        .crit_wr_ok   (crit_wr_ok)
    );

    assign out_on = cfg.en & ~cfg.sd;

    thal_irq_track u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .int_mode   (cfg.mode),
        .active     (~cfg.sd),
        .sample_stb (sample_stb),
        .trip_above (trip_above),
        .trip_below (trip_below),
        .trip_crit  (trip_crit),
        .clr_req    (clr_req),
        .irq_hold   (irq_hold)
    );

    // Pick the alert condition for the selected mode.
    always_comb begin
        if (cfg.crit_only)
            cond = trip_crit;
        else if (cfg.mode)
            cond = trip_crit | irq_hold;
        else
            cond = trip_crit | trip_above | trip_below;
    end

    assign asserted = cond & out_on;

    thal_pin_drive u_pin (
        .asserted  (asserted),
        .out_on    (out_on),
        .pol_high  (cfg.pol),
        .pin_oe    (alert_oe),
        .pin_level (alert_level)
    );

    // Assemble the host view; clear reads 0, status is polarity-free.
    assign cfg_rdata = {{RSV_W{1'b0}}, cfg.hyst, cfg.sd, cfg.crit_lock, cfg.win_lock,
                        1'b0, asserted, cfg.en, cfg.crit_only, cfg.pol, cfg.mode};

    a_r6_crit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.crit_only && !trip_crit) |-> !cfg_rdata[B_STAT]) else $error("a_r6_crit_only");
    a_r10_sd_release: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.sd |-> (!alert_oe && alert_level && !cfg_rdata[B_STAT])) else $error("a_r10_sd_release");
    a_r7_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !alert_oe) else $error("a_r7_disabled");
    a_r3_comp_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.mode && !cfg.crit_only && out_on && (trip_above || trip_below)) |-> cfg_rdata[B_STAT])
        else $error("a_r3_comp_follow");
endmodule

// File: tb/tb_thermal_alert_ctrl.sv
module tb_thermal_alert_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        trip_crit, trip_above, trip_below, sample_stb;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic [15:0] cfg_rdata;
    logic        alert_level, alert_oe, win_hi_wr_ok, win_lo_wr_ok, crit_wr_ok;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_alert_ctrl dut (
        .clk(clk), .rst_n(rst_n), .trip_crit(trip_crit), .trip_above(trip_above),
        .trip_below(trip_below), .sample_stb(sample_stb), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .cfg_rdata(cfg_rdata),
        .alert_level(alert_level), .alert_oe(alert_oe), .win_hi_wr_ok(win_hi_wr_ok),
        .win_lo_wr_ok(win_lo_wr_ok), .crit_wr_ok(crit_wr_ok)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%04h expected=0x%04h", tag, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'h0;
    endtask

    task automatic sample(input logic a, input logic b, input logic c);
        @(negedge clk);
        trip_above = a; trip_below = b; trip_crit = c; sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
    endtask

    task automatic pin_check(input string tag, input logic oe);
        check({tag, " oe"}, {15'b0, alert_oe}, {15'b0, oe});
        check({tag, " level"}, {15'b0, alert_level}, {15'b0, ~oe});
    endtask

    task automatic t_reset;
        check("R1 reset cfg", cfg_rdata, 16'h0000);
        pin_check("R1 reset pin", 1'b0);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; #1;
        check("R1 hi permit", {15'b0, win_hi_wr_ok}, 16'h1);
        wr_sel = 2'd3; #1;
        check("R1 crit permit", {15'b0, crit_wr_ok}, 16'h1);
        wr_en = 1'b0; wr_sel = 2'd0;
    endtask

    task automatic t_fields;
        write_reg(2'd0, 16'h0038);
        check("R2 status/clear ignored", cfg_rdata, 16'h0008);
        write_reg(2'd0, 16'hF80F);
        check("R2 reserved read 0", cfg_rdata, 16'h000F);
        write_reg(2'd0, 16'h0608);
        check("R2 hyst field", cfg_rdata, 16'h0608);
    endtask

    task automatic t_comparator;
        write_reg(2'd0, 16'h0008);
        sample(1'b1, 1'b0, 1'b0);
        check("R3 above asserts", cfg_rdata, 16'h0018);
        pin_check("R3 pin active-low", 1'b1);
        write_reg(2'd0, 16'h0028);
        check("R3 clear no effect", cfg_rdata, 16'h0018);
        sample(1'b0, 1'b1, 1'b0);
        check("R3 below asserts", cfg_rdata, 16'h0018);
        sample(1'b0, 1'b0, 1'b0);
        check("R3 inside window", cfg_rdata, 16'h0008);
        pin_check("R3 pin released", 1'b0);
    endtask

    task automatic t_interrupt;
        write_reg(2'd0, 16'h0009);
        check("R4 idle int", cfg_rdata, 16'h0009);
        sample(1'b1, 1'b0, 1'b0);
        check("R4 leave window latches", cfg_rdata, 16'h0019);
        sample(1'b0, 1'b0, 1'b0);
        check("R4 stays after return", cfg_rdata, 16'h0019);
        write_reg(2'd0, 16'h0029);
        check("R4 clear deasserts", cfg_rdata, 16'h0009);
        pin_check("R4 pin after clear", 1'b0);
        sample(1'b0, 1'b1, 1'b0);
        check("R4 below latches", cfg_rdata, 16'h0019);
        write_reg(2'd0, 16'h0029);
        sample(1'b0, 1'b1, 1'b0);
        check("R4 steady no retrigger", cfg_rdata, 16'h0009);
    endtask

    task automatic t_critical;
        sample(1'b1, 1'b0, 1'b0);
        write_reg(2'd0, 16'h0029);
        sample(1'b1, 1'b0, 1'b1);
        check("R5 crit asserts after clear", cfg_rdata, 16'h0019);
        write_reg(2'd0, 16'h0029);
        check("R5 clear blocked by crit", cfg_rdata, 16'h0019);
        sample(1'b1, 1'b0, 1'b0);
        check("R5 crit drop releases", cfg_rdata, 16'h0009);
        sample(1'b0, 1'b0, 1'b0);
        sample(1'b1, 1'b0, 1'b1);
        write_reg(2'd0, 16'h0029);
        check("R5 pending clear held", cfg_rdata, 16'h0019);
        @(negedge clk);
        trip_crit = 1'b0; #1;
        check("R5 pending clear immediate", cfg_rdata, 16'h0009);
        sample(1'b0, 1'b0, 1'b1);
        sample(1'b0, 1'b0, 1'b0);
        check("R5 no clear keeps latch", cfg_rdata, 16'h0019);
        write_reg(2'd0, 16'h0029);
        check("R5 later clear", cfg_rdata, 16'h0009);
    endtask

    task automatic t_crit_only;
        write_reg(2'd0, 16'h000C);
        sample(1'b1, 1'b0, 1'b0);
        check("R6 window ignored", cfg_rdata, 16'h000C);
        sample(1'b1, 1'b0, 1'b1);
        check("R6 crit asserts", cfg_rdata, 16'h001C);
        sample(1'b0, 1'b0, 1'b0);
        check("R6 crit clears", cfg_rdata, 16'h000C);
    endtask

    task automatic t_polarity;
        write_reg(2'd0, 16'h000A);
        check("R7 active-high idle", cfg_rdata, 16'h000A);
        pin_check("R7 idle pulled", 1'b1);
        sample(1'b1, 1'b0, 1'b0);
        check("R7 status polarity-free", cfg_rdata, 16'h001A);
        pin_check("R7 asserted released", 1'b0);
        write_reg(2'd0, 16'h0002);
        check("R7 disabled no status", cfg_rdata, 16'h0002);
        pin_check("R7 disabled released", 1'b0);
        sample(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_shutdown;
        sample(1'b1, 1'b0, 1'b0);
        write_reg(2'd0, 16'h0108);
        check("R10 shutdown no alert", cfg_rdata, 16'h0108);
        pin_check("R10 shutdown pin", 1'b0);
        write_reg(2'd0, 16'h0008);
        check("R10 wake alerts", cfg_rdata, 16'h0018);
        sample(1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_locks;
        write_reg(2'd0, 16'h0108);
        write_reg(2'd0, 16'h0148);
        check("R8 lock set same write", cfg_rdata, 16'h0148);
        write_reg(2'd0, 16'h0048);
        check("R10 shutdown clears under lock", cfg_rdata, 16'h0048);
        write_reg(2'd0, 16'h0148);
        check("R10 shutdown set blocked", cfg_rdata, 16'h0048);
        write_reg(2'd0, 16'h0607);
        check("R8 fields frozen", cfg_rdata, 16'h0048);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; #1;
        check("R9 hi blocked", {15'b0, win_hi_wr_ok}, 16'h0);
        wr_sel = 2'd2; #1;
        check("R9 lo blocked", {15'b0, win_lo_wr_ok}, 16'h0);
        wr_sel = 2'd3; #1;
        check("R9 crit open", {15'b0, crit_wr_ok}, 16'h1);
        wr_en = 1'b0; wr_sel = 2'd0;
        write_reg(2'd0, 16'h06C7);
        check("R8 crit lock added", cfg_rdata, 16'h00C8);
        write_reg(2'd0, 16'h0000);
        check("R8 locks sticky", cfg_rdata, 16'h00C8);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd3; #1;
        check("R9 crit blocked", {15'b0, crit_wr_ok}, 16'h0);
        wr_en = 1'b0; wr_sel = 2'd0;
    endtask

    initial begin
        rst_n = 1'b0; trip_crit = 0; trip_above = 0; trip_below = 0; sample_stb = 0;
        wr_en = 0; wr_sel = 0; wr_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_comparator();
        t_interrupt();
        t_critical();
        t_crit_only();
        t_polarity();
        t_shutdown();
        t_locks();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule